// File: doc/BRIEF.md
# Random-Number Peripheral with Word-Read Byte FIFO

This block sits between a hardware entropy source and software. Random bytes arrive on a valid/ready byte stream. While the generator is enabled, the block stores them in a byte FIFO and adds eight to a running bit total for every accepted byte. Software uses a 32-bit register bus to do four things: enable the generator, set thresholds, inspect and acknowledge interrupt flags, and drain the FIFO as packed 32-bit words.

A single level-sensitive interrupt output is high while any pending status flag is also enabled. Software has a dedicated register that returns the block to its power-on state. It empties the FIFO and leaves only the start-up flag pending. A companion reset register for the bit generator is accepted but has no effect. The health-test and lockout flags exist as register fields only, because no logic in this block sets them.

Top module: `rng_fifo_periph`

## Requirements
- R1: After reset, the bus reads are: control 0, bit total 0, bit threshold 0, interrupt enable 0, FIFO count 0, data 0, and status 0x0002_0000 (only the start-up flag, bit 17). `irq` and `ent_ready` are low.
- R2: Control register (offset 0x00) layout:
  - Bit 0 is the generator enable. Bits 20:13 hold an 8-bit divider value. All other bits read 0.
  - `ent_ready` is high exactly when the generator is enabled and the FIFO is not full.
- R3: A byte is accepted only when `ent_valid` and `ent_ready` are both high. The FIFO never holds more than `FIFO_DEPTH` bytes.
- R4: Bit total register (offset 0x0C):
  - A control write that takes the enable from 0 to 1 loads the total with 17.
  - Every accepted byte adds 8 to the total.
  - Writes to this register are ignored.
- R5: A write to the threshold register (offset 0x10) stores the value and loads the bit total with the value plus one. This load overrides the increment from a byte accepted in the same cycle.
- R6: A read of the data register (offset 0x20) pops up to four bytes:
  - The oldest byte goes in bits 7:0, the next in 15:8, and so on.
  - An empty FIFO returns 0.
  - With fewer than four bytes held, the missing upper bytes read as 0.
- R7: FIFO count register (offset 0x24):
  - Bits 7:0 always read the number of bytes held divided by 4, rounded down. Writes to these bits are ignored.
  - Bits 15:8 are a writable occupancy threshold.
- R8: Status bit 0 is set when a byte is accepted and the resulting occupancy in bytes exceeds the occupancy threshold. If a status clear hits bit 0 in the same cycle, the set wins.
- R9: Status (offset 0x18) and enable (offset 0x1C) share one layout: bit 0 fill, bit 5 health failure, bit 17 start-up, bit 30 lockout.
  - Writing status clears each of those bits written as 1 and leaves the others unchanged.
  - The enable register stores only those four bits.
- R10: `irq` is high exactly when some status bit and its enable bit are both 1. It follows a status or enable change one cycle after the register write.
- R11: Generator soft reset (offset 0x04):
  - Writing it with bit 0 set clears every register, empties the FIFO, discards any byte offered in that cycle, and leaves only status bit 17 pending.
  - Writing the bit-generator soft reset register (offset 0x08) changes nothing.
  - Both reset registers read as 0.
- R12: Reads of unmapped offsets (for example 0x14 or 0x40) return 0, and writes to them change nothing.
- R13: A data-register read and a byte acceptance in the same cycle both take effect. The occupancy changes by the bytes pushed minus the bytes popped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_valid | input | 1 | Entropy byte offered |
| ent_byte | input | 8 | Entropy byte value |
| ent_ready | output | 1 | Block can take a byte this cycle |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle; 0 otherwise |
| irq | output | 1 | Level interrupt |

## Verification
Entropy is streamed in three patterns, and each one separates different faults:
- Short bursts below a word boundary show whether packing is correct and whether partial words are zero-filled.
- A long stream past the FIFO depth shows whether back-pressure drops `ent_ready` exactly at full, and whether bytes offered while full are lost.
- Pushes interleaved with data reads show whether a same-cycle pop and push are both counted, and whether a read takes the oldest bytes even when a new byte lands at the tail.

Threshold writes, enable toggles and soft resets are placed between these patterns. This separates a load of the bit total from an increment, and a status set from a clear.

// File: rtl/rngp_pkg.sv
package rngp_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    // register offsets seen by software
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_GEN_RST = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_BIT_RST = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_BITCNT  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_BITTHR  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_IRQ_ST  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_IRQ_EN  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_DATA    = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_FCOUNT  = 8'h24;

    // interrupt flag positions in status / enable words
    localparam int IRQ_FILL    = 0;
    localparam int IRQ_HEALTH  = 5;
    localparam int IRQ_STARTUP = 17;
    localparam int IRQ_LOCKOUT = 30;

    // control word fields
    localparam int EN_BIT  = 0;
    localparam int DIV_LSB = 13;
    localparam int DIV_W   = 8;

    // FIFO count word fields
    localparam int FCNT_W      = 8;
    localparam int FTHR_LSB    = 8;
    localparam int BYTES_PER_W = DATA_W / 8;

    localparam logic [DATA_W-1:0] WARMUP_PRELOAD = 32'd17;
    localparam logic [DATA_W-1:0] BITS_PER_BYTE  = 32'd8;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_GEN_RST,
        SEL_BIT_RST,
        SEL_BITCNT,
        SEL_BITTHR,
        SEL_IRQ_ST,
        SEL_IRQ_EN,
        SEL_DATA,
        SEL_FCOUNT
    } reg_sel_e;

    typedef struct packed {
        logic lockout;
        logic startup;
        logic health;
        logic fill;
    } irq_vec_t;

    typedef struct packed {
        logic             enable;
        logic [DIV_W-1:0] divider;
    } ctrl_t;

    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_CTRL:    s = SEL_CTRL;
            OFS_GEN_RST: s = SEL_GEN_RST;
            OFS_BIT_RST: s = SEL_BIT_RST;
            OFS_BITCNT:  s = SEL_BITCNT;
            OFS_BITTHR:  s = SEL_BITTHR;
            OFS_IRQ_ST:  s = SEL_IRQ_ST;
            OFS_IRQ_EN:  s = SEL_IRQ_EN;
            OFS_DATA:    s = SEL_DATA;
            OFS_FCOUNT:  s = SEL_FCOUNT;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic irq_vec_t irq_from_word(logic [DATA_W-1:0] w);
        irq_vec_t v;
        v.fill    = w[IRQ_FILL];
        v.health  = w[IRQ_HEALTH];
        v.startup = w[IRQ_STARTUP];
        v.lockout = w[IRQ_LOCKOUT];
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] irq_to_word(irq_vec_t v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[IRQ_FILL]    = v.fill;
        w[IRQ_HEALTH]  = v.health;
        w[IRQ_STARTUP] = v.startup;
        w[IRQ_LOCKOUT] = v.lockout;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[EN_BIT] = c.enable;
        w[DIV_LSB +: DIV_W] = c.divider;
        return w;
    endfunction

endpackage

// File: rtl/rngp_byte_fifo.sv
module rngp_byte_fifo
    import rngp_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              push,
    input  logic [7:0]        push_byte,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_word,
    output logic [OCC_W-1:0]  occ,
    output logic [OCC_W-1:0]  occ_nxt
);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic [OCC_W-1:0] occ_q;
    logic [2:0]       take;

    // bytes a read would remove: up to one word's worth
    always_comb begin
        if (occ_q >= OCC_W'(BYTES_PER_W)) take = 3'(BYTES_PER_W);
        else                              take = 3'(occ_q);
    end

    // oldest byte lands in the lowest lane, missing lanes read zero
    for (genvar g = 0; g < BYTES_PER_W; g++) begin : g_lane
        assign pop_word[8*g +: 8] = (3'(g) < take) ? mem[rd_ptr + PTR_W'(g)] : 8'h00;
    end

    always_comb begin
        occ_nxt = occ_q + OCC_W'(push) - (pop ? OCC_W'(take) : '0);
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_byte;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            occ_q  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + PTR_W'(take);
            occ_q <= occ_nxt;
        end
    end

    assign occ = occ_q;

endmodule

// File: rtl/rngp_bit_counter.sv
module rngp_bit_counter
    import rngp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              warm_load,
    input  logic              thr_we,
    input  logic [DATA_W-1:0] thr_wdata,
    input  logic              add_byte,
    output logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] thresh
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count  <= '0;
            thresh <= '0;
        end else if (thr_we) begin
            thresh <= thr_wdata;
            count  <= thr_wdata + 32'd1;
        end else if (warm_load) begin
            count <= WARMUP_PRELOAD;
        end else if (add_byte) begin
            count <= count + BITS_PER_BYTE;
        end
    end

endmodule

// File: rtl/rngp_irq_regs.sv
module rngp_irq_regs
    import rngp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              en_we,
    input  logic [DATA_W-1:0] en_wdata,
    input  logic              st_clr_we,
    input  logic [DATA_W-1:0] st_clr_mask,
    input  logic              fill_evt,
    output irq_vec_t          status,
    output irq_vec_t          enable,
    output logic              irq
);

    irq_vec_t st_q;
    irq_vec_t en_q;
    irq_vec_t st_d;

    always_comb begin
        st_d = st_q;
        if (st_clr_we) st_d = irq_vec_t'(st_q & ~irq_from_word(st_clr_mask));
        if (fill_evt)  st_d.fill = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            st_q         <= '0;
            st_q.startup <= 1'b1;
            en_q         <= '0;
        end else begin
            st_q <= st_d;
            if (en_we) en_q <= irq_from_word(en_wdata);
        end
    end

    assign status = st_q;
    assign enable = en_q;
    assign irq    = |(st_q & en_q);

endmodule

// File: rtl/rng_fifo_periph.sv
module rng_fifo_periph
    import rngp_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    localparam int OCC_W = $clog2(FIFO_DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ent_valid,
    input  logic [7:0]  ent_byte,
    output logic        ent_ready,
    input  logic        reg_en,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);

    reg_sel_e          sel;
    logic              wr_hit;
    logic              rd_hit;
    logic              gen_rst;
    logic              gen_en;
    logic              push;
    logic              pop;
    logic              warm_load;
    logic              fill_evt;
    ctrl_t             ctrl_q;
    logic [7:0]        fthr_q;
    logic [OCC_W-1:0]  occ;
    logic [OCC_W-1:0]  occ_nxt;
    logic [DATA_W-1:0] pop_word;
    logic [DATA_W-1:0] bit_count;
    logic [DATA_W-1:0] bit_thresh;
    irq_vec_t          st;
    irq_vec_t          ie;

    assign sel     = decode_addr(reg_addr);
    assign wr_hit  = reg_en && reg_we;
    assign rd_hit  = reg_en && !reg_we;
    assign gen_rst = wr_hit && (sel == SEL_GEN_RST) && reg_wdata[0];
    assign gen_en  = ctrl_q.enable;

    assign ent_ready = gen_en && (occ != OCC_W'(FIFO_DEPTH));
    assign push      = ent_valid && ent_ready && !gen_rst;
    assign pop       = rd_hit && (sel == SEL_DATA);
    assign warm_load = wr_hit && (sel == SEL_CTRL) && !gen_en && reg_wdata[EN_BIT];
    assign fill_evt  = push && (occ_nxt > OCC_W'(fthr_q));

    always_ff @(posedge clk) begin
        if (rst || gen_rst) begin
            ctrl_q <= '0;
            fthr_q <= '0;
        end else if (wr_hit) begin
            if (sel == SEL_CTRL) begin
                ctrl_q.enable  <= reg_wdata[EN_BIT];
                ctrl_q.divider <= reg_wdata[DIV_LSB +: DIV_W];
            end
            if (sel == SEL_FCOUNT) fthr_q <= reg_wdata[FTHR_LSB +: 8];
        end
    end

    rngp_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .clear    (gen_rst),
        .push     (push),
        .push_byte(ent_byte),
        .pop      (pop),
        .pop_word (pop_word),
        .occ      (occ),
        .occ_nxt  (occ_nxt)
    );

    rngp_bit_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clear    (gen_rst),
        .warm_load(warm_load),
        .thr_we   (wr_hit && (sel == SEL_BITTHR)),
        .thr_wdata(reg_wdata),
        .add_byte (push),
        .count    (bit_count),
        .thresh   (bit_thresh)
    );

    rngp_irq_regs u_irq (
        .clk        (clk),
        .rst        (rst),
        .clear      (gen_rst),
        .en_we      (wr_hit && (sel == SEL_IRQ_EN)),
        .en_wdata   (reg_wdata),
        .st_clr_we  (wr_hit && (sel == SEL_IRQ_ST)),
        .st_clr_mask(reg_wdata),
        .fill_evt   (fill_evt),
        .status     (st),
        .enable     (ie),
        .irq        (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (rd_hit) begin
            case (sel)
                SEL_CTRL:   reg_rdata = ctrl_to_word(ctrl_q);
                SEL_BITCNT: reg_rdata = bit_count;
                SEL_BITTHR: reg_rdata = bit_thresh;
                SEL_IRQ_ST: reg_rdata = irq_to_word(st);
                SEL_IRQ_EN: reg_rdata = irq_to_word(ie);
                SEL_DATA:   reg_rdata = pop_word;
                SEL_FCOUNT: reg_rdata = {16'h0, fthr_q, FCNT_W'(occ >> 2)};
                default:    reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/rngp_checker.sv
module rngp_checker #(
    parameter int DEPTH = 128,
    localparam int OCC_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_en,
    input logic             reg_we,
    input logic [7:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic             ent_valid,
    input logic             ent_ready,
    input logic             irq,
    input logic             gen_en,
    input logic [OCC_W-1:0] occ,
    input logic [31:0]      bit_count
);

    logic sreset_wr;
    logic data_rd;
    logic accept;

    assign sreset_wr = reg_en && reg_we && reg_addr == 8'h04 && reg_wdata[0];
    assign data_rd   = reg_en && !reg_we && reg_addr == 8'h20;
    assign accept    = ent_valid && ent_ready;

    // R3
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(DEPTH));

    // R3
    a_r3_accept_grows: assert property (@(posedge clk) disable iff (rst)
        (accept && !sreset_wr && !data_rd) |=> occ == $past(occ) + 1'b1);

    // R4
    a_r4_warmup_load: assert property (@(posedge clk) disable iff (rst)
        (reg_en && reg_we && reg_addr == 8'h00 && reg_wdata[0] && !gen_en) |=> bit_count == 32'd17);

    // R5
    a_r5_thr_load: assert property (@(posedge clk) disable iff (rst)
        (reg_en && reg_we && reg_addr == 8'h10) |=> bit_count == $past(reg_wdata) + 32'd1);

    // R6
    a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
        (data_rd && occ == '0) |-> reg_rdata == 32'h0);

    // R10
    a_r10_mask_off: assert property (@(posedge clk) disable iff (rst)
        (reg_en && reg_we && reg_addr == 8'h1C && reg_wdata == 32'h0) |=> !irq);

    // R11
    a_r11_soft_reset: assert property (@(posedge clk) disable iff (rst)
        sreset_wr |=> (occ == '0 && !gen_en && !irq && bit_count == 32'h0));

    // R13
    a_r13_read_and_push: assert property (@(posedge clk) disable iff (rst)
        (data_rd && accept && occ >= OCC_W'(4)) |=> occ == $past(occ) - OCC_W'(3));

endmodule

bind rng_fifo_periph rngp_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_en   (reg_en),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .ent_valid(ent_valid),
    .ent_ready(ent_ready),
    .irq      (irq),
    .gen_en   (gen_en),
    .occ      (occ),
    .bit_count(bit_count)
);

// File: tb/sim_rng_fifo_periph.sv
`timescale 1ns/1ps
module sim_rng_fifo_periph;

    localparam int DEPTH = 128;
    localparam logic [31:0] IRQ_MASK = 32'h4002_0021;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ent_valid = 1'b0;
    logic [7:0]  ent_byte = 8'h0;
    logic        ent_ready;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #2 clk = ~clk;

    rng_fifo_periph #(.FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .ent_valid(ent_valid), .ent_byte(ent_byte),
        .ent_ready(ent_ready), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [7:0] seed = 8'h5A;

    // behavioural reference model
    byte unsigned mq[$];
    logic        m_en;
    logic [7:0]  m_div;
    logic [31:0] m_cnt, m_thr, m_st, m_ie;
    logic [7:0]  m_fthr;

    function automatic void m_reset();
        mq.delete();
        m_en = 0; m_div = 0; m_cnt = 0; m_thr = 0;
        m_st = 32'h0002_0000; m_ie = 0; m_fthr = 0;
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        logic [31:0] w;
        w = 0;
        case (a)
            8'h00: w = {11'b0, m_div, 12'b0, m_en};
            8'h0C: w = m_cnt;
            8'h10: w = m_thr;
            8'h18: w = m_st;
            8'h1C: w = m_ie;
            8'h20: for (int i = 0; i < 4 && i < mq.size(); i++) w[8*i +: 8] = mq[i];
            8'h24: w = {16'b0, m_fthr, 8'(mq.size() / 4)};
            default: w = 0;
        endcase
        return w;
    endfunction

    always @(posedge clk) begin
        if (rst) m_reset();
        else begin
            automatic bit rdy = m_en && mq.size() < DEPTH;
            automatic bit psh = ent_valid && rdy;
            automatic bit wr  = reg_en && reg_we;
            automatic bit rd  = reg_en && !reg_we;
            automatic bit evt;
            if (wr && reg_addr == 8'h04 && reg_wdata[0]) m_reset();   // R11
            else begin
                if (rd && reg_addr == 8'h20)
                    for (int i = 0; i < 4; i++) if (mq.size() > 0) void'(mq.pop_front());
                if (psh) mq.push_back(ent_byte);
                evt = psh && (mq.size() > m_fthr);                      // R8
                if (wr && reg_addr == 8'h18) m_st = m_st & ~reg_wdata;  // R9
                if (evt) m_st[0] = 1'b1;
                if (wr && reg_addr == 8'h1C) m_ie = reg_wdata & IRQ_MASK;
                if (wr && reg_addr == 8'h00) begin
                    if (!m_en && reg_wdata[0]) m_cnt = 32'd17;          // R4
                    m_en  = reg_wdata[0];
                    m_div = reg_wdata[20:13];
                end
                if (wr && reg_addr == 8'h24) m_fthr = reg_wdata[15:8];
                if (wr && reg_addr == 8'h10) begin                      // R5
                    m_thr = reg_wdata;
                    m_cnt = reg_wdata + 32'd1;
                end else if (psh) m_cnt = m_cnt + 32'd8;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // per-cycle comparison of irq (R10) and ready (R2)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R10 irq", {31'b0, irq}, {31'b0, |(m_st & m_ie)});
            chk("R2 ent_ready", {31'b0, ent_ready}, {31'b0, m_en && mq.size() < DEPTH});
        end
    end

    task automatic drive(input string req, input bit en, input bit we, input logic [7:0] a,
                         input logic [31:0] d, input bit v);
        @(negedge clk);
        reg_en = en; reg_we = we; reg_addr = a; reg_wdata = d;
        ent_valid = v; ent_byte = seed;
        if (v) seed = seed * 8'd5 + 8'd29;
        #1;
        if (en && !we) chk(req, reg_rdata, m_read(a));
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        drive("", 1, 1, a, d, 0);
    endtask

    task automatic rd(input string req, input logic [7:0] a);
        drive(req, 1, 0, a, 0, 0);
    endtask

    task automatic feed(input int n);
        for (int i = 0; i < n; i++) drive("", 0, 0, 0, 0, 1);
    endtask

    task automatic idle();
        drive("", 0, 0, 0, 0, 0);
    endtask

    task automatic read_all(input string req);
        rd({req, " ctrl"}, 8'h00);
        rd({req, " bitcnt"}, 8'h0C);
        rd({req, " bitthr"}, 8'h10);
        rd({req, " status"}, 8'h18);
        rd({req, " ien"}, 8'h1C);
        rd({req, " fcount"}, 8'h24);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state, explicit values
        rd("R1 status", 8'h18); chk("R1 status value", reg_rdata, 32'h0002_0000);
        read_all("R1");
        rd("R1 R6 empty data", 8'h20);
        chk("R1 ready low", {31'b0, ent_ready}, 32'h0);

        // R2 control layout, R4 warm-up load
        wr(8'h00, 32'hFFFF_FFFF);
        rd("R2 ctrl", 8'h00); chk("R2 ctrl value", reg_rdata, 32'h001F_E001);
        rd("R4 warmup", 8'h0C); chk("R4 value 17", reg_rdata, 32'd17);
        wr(8'h0C, 32'h1234);                       // R4 write ignored
        rd("R4 bitcnt ro", 8'h0C);

        // R6/R7 short burst, partial words; R8 fill flag with threshold 0
        feed(6);
        read_all("R7 R8 burst6");
        rd("R6 word", 8'h20);
        rd("R6 partial", 8'h20);
        rd("R6 empty", 8'h20);
        wr(8'h18, 32'hFFFF_FFFF);                  // R9 clear all
        read_all("R9 clear");

        // R7 threshold field, count field write ignored
        wr(8'h24, 32'hABCD_05FF);
        feed(5);
        read_all("R7 R8 thr5 five");
        feed(2);
        read_all("R8 above thr");

        // R9 enable layout, R10 irq
        wr(8'h1C, 32'hFFFF_FFFF);
        idle();
        read_all("R9 R10 ien");
        wr(8'h18, 32'h0000_0001);                  // R9 clear only fill
        idle();
        read_all("R9 partial clear");
        feed(1);                                   // R8 sets fill again
        idle();
        rd("R8 refill", 8'h18);

        // R13 read and push in same cycle
        for (int i = 0; i < 4; i++) drive("R13 read+push", 1, 0, 8'h20, 0, 1);
        read_all("R13 after");

        // R5 threshold load, overrides same-cycle byte
        drive("", 1, 1, 8'h10, 32'd100, 1);
        read_all("R5 thr");
        drive("", 1, 1, 8'h10, 32'hFFFF_FFFF, 0);
        rd("R5 wrap", 8'h0C);

        // R8 set wins over clear in same cycle
        wr(8'h24, 32'h0000_0000);
        drive("", 1, 1, 8'h18, 32'hFFFF_FFFF, 1);
        rd("R8 set wins", 8'h18);

        // R3 fill past depth, back-pressure
        feed(DEPTH + 6);
        read_all("R3 full");
        for (int i = 0; i < 3; i++) rd("R3 R6 drain", 8'h20);
        feed(3);
        read_all("R3 refill");

        // R4 disable then enable again reloads 17
        wr(8'h00, 32'h0000_4000);
        feed(2);
        read_all("R4 disabled");
        wr(8'h00, 32'h0000_0001);
        rd("R4 reload", 8'h0C); chk("R4 value 17 again", reg_rdata, 32'd17);

        // R11 bit-generator reset does nothing, reset regs read 0
        wr(8'h08, 32'hFFFF_FFFF);
        read_all("R11 bitgen reset");
        rd("R11 rst reg reads 0", 8'h04);
        rd("R11 rst reg reads 0", 8'h08);

        // R12 unmapped
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        rd("R12 unmapped 14", 8'h14);
        rd("R12 unmapped 40", 8'h40);
        read_all("R12 unchanged");

        // R11 generator soft reset while a byte is offered
        drive("", 1, 1, 8'h04, 32'h0000_0001, 1);
        read_all("R11 soft reset");
        rd("R11 fifo empty", 8'h20);
        rd("R11 status", 8'h18); chk("R11 status value", reg_rdata, 32'h0002_0000);

        // R6 drain of many words after re-enable
        wr(8'h00, 32'h1);
        feed(10);
        for (int i = 0; i < 4; i++) rd("R6 drain", 8'h20);
        read_all("R6 end");

        idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule